// File: doc/BRIEF.md
# Speculative Fetch Window Tracker

This block guards instruction prefetch while every address-translation stage of a regime is switched off. In that state there is no page table to say which memory tolerates speculative reads, so the tracker keeps its own record: the granule-aligned memory blocks that committed, in-order execution has actually fetched from. A speculative or prefetch fetch is granted only if it falls inside one of those recorded blocks or inside the block that directly follows one. Whether the prefetched instruction is ever committed makes no difference to the decision.

The record lives in a small fully associative table filled round-robin. Reset empties it. An instruction-cache maintenance event that targets an address removes the block holding that address. A branch-predictor maintenance event does the same, but only while its enable mode input is high. Losing an entry to replacement only shrinks the permitted window, so replacement can never grant a fetch that the rule forbids.

The prefetch check is combinational. It sees the table as it will stand after the current cycle's maintenance. It also sees a committed fetch presented in the same cycle, so a block is usable in the cycle it is first needed.

Top module: `spec_fetch_window`

## Requirements
- R1: An address maps to block index `addr >> log2(GRANULE_BYTES)` (default granule 4096 bytes). Two addresses in the same aligned granule always receive the same decision.
- R2: `probe_allow` is 1 in the same cycle as `probe_valid` exactly when the probe's block equals a recorded block, or equals a recorded block plus one.
- R3: After reset, and after any later reset, no block is recorded and every probe is denied until a committed fetch is seen.
- R4: A committed fetch (`fetch_valid`) records its block from the next cycle on. A probe in the same cycle as the fetch already counts that block.
- R5: An `icm_valid` event removes the block holding `icm_addr`. A probe in the same cycle no longer counts that block.
- R6: A `bpm_valid` event removes the block holding `bpm_addr` when `bpm_en` is 1. When `bpm_en` is 0 the event has no effect.
- R7: When a maintenance event and a committed fetch name the same block in one cycle, the block is not recorded. A probe in that cycle does not count it either.
- R8: The block following the highest block of the address space is block 0, with no error raised.
- R9: A block already recorded is never stored twice. When the table holds ENTRIES valid blocks, a new block replaces entries in round-robin order, oldest allocation first. A repeated fetch to a recorded block does not advance the order.
- R10: `probe_allow` is 0 whenever `probe_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the table |
| fetch_valid | input | 1 | A committed sequential instruction fetch is presented |
| fetch_addr | input | ADDR_W | Address of the committed fetch |
| probe_valid | input | 1 | A speculative fetch asks for permission |
| probe_addr | input | ADDR_W | Address of the speculative fetch |
| probe_allow | output | 1 | Permission for the speculative fetch, same cycle |
| icm_valid | input | 1 | Synchronized instruction-cache maintenance event |
| icm_addr | input | ADDR_W | Target address of the cache maintenance |
| bpm_en | input | 1 | Mode: branch-predictor maintenance also clears blocks |
| bpm_valid | input | 1 | Branch-predictor maintenance event |
| bpm_addr | input | ADDR_W | Target address of the predictor maintenance |

## Verification
The bench builds the tracker with a 20-bit address, the default 4 KiB granule and four entries. The narrow address leaves only 256 blocks, so the last block and its wrap to block 0 can be reached with ordinary addresses. Four entries let replacement, and the rule that a repeated fetch does not advance the order, show up within a handful of fetches. A behavioural model in the bench, built on integer arrays, predicts `probe_allow` every cycle, and the key corner cases also carry hand-computed expectations.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

  // log2 of a power-of-two granule size in bytes
  function automatic int gran_shift(input int bytes);
    int s;
    s = 0;
    while ((1 << s) < bytes) s++;
    return s;
  endfunction

  // pointer width for a table of n entries (at least one bit)
  function automatic int ptr_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sfw_near.sv
// Reports whether target block lies in the window of a recorded block:
// the block itself or its successor (wrapping at the top).
module sfw_near #(
  parameter int BW = 20
) (
  input  logic          en,
  input  logic [BW-1:0] rec,
  input  logic [BW-1:0] tgt,
  output logic          hit
);
  function automatic logic [BW-1:0] succ(input logic [BW-1:0] b);
    return b + {{(BW-1){1'b0}}, 1'b1};
  endfunction

  assign hit = en & ((rec == tgt) | (succ(rec) == tgt));
endmodule

// File: rtl/sfw_rr_ptr.sv
// Round-robin allocation pointer with one-hot slot select.
module sfw_rr_ptr #(
  parameter int ENTRIES = 8,
  localparam int PW = sfw_pkg::ptr_bits(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  output logic [PW-1:0]      ptr,
  output logic [ENTRIES-1:0] sel
);
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + {{(PW-1){1'b0}}, 1'b1};
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_sel
    assign sel[i] = (ptr == PW'(i));
  end
endmodule

// File: rtl/sfw_slot.sv
// One table entry: a recorded block and its valid flag.
module sfw_slot #(
  parameter int BW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic          kill_a_en,
  input  logic [BW-1:0] kill_a_blk,
  input  logic          kill_b_en,
  input  logic [BW-1:0] kill_b_blk,
  input  logic [BW-1:0] probe_blk,
  input  logic [BW-1:0] look_blk,
  output logic          vld,
  output logic [BW-1:0] blk,
  output logic          same_look,
  output logic          covers,
  output logic          doomed
);
  assign doomed    = vld & ((kill_a_en & (blk == kill_a_blk)) |
                            (kill_b_en & (blk == kill_b_blk)));
  assign same_look = vld & (blk == look_blk);

  sfw_near #(.BW(BW)) u_near (
    .en  (vld & ~doomed),
    .rec (blk),
    .tgt (probe_blk),
    .hit (covers)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= 1'b0;
      blk <= '0;
    end else if (wr_en) begin
      vld <= 1'b1;
      blk <= wr_blk;
    end else if (doomed) begin
      vld <= 1'b0;
    end
  end
endmodule

// File: rtl/spec_fetch_window.sv
module spec_fetch_window #(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 4096,
  parameter int ENTRIES       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic              probe_allow,
  input  logic              icm_valid,
  input  logic [ADDR_W-1:0] icm_addr,
  input  logic              bpm_en,
  input  logic              bpm_valid,
  input  logic [ADDR_W-1:0] bpm_addr
);
  localparam int GSH = sfw_pkg::gran_shift(GRANULE_BYTES);
  localparam int BW  = ADDR_W - GSH;
  localparam int PW  = sfw_pkg::ptr_bits(ENTRIES);

  typedef logic [BW-1:0] blk_t;

  function automatic blk_t blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:GSH];
  endfunction

  // block indices of every address input
  blk_t fetch_blk, probe_blk, icm_blk, bpm_blk;
  assign fetch_blk = blk_of(fetch_addr);
  assign probe_blk = blk_of(probe_addr);
  assign icm_blk   = blk_of(icm_addr);
  assign bpm_blk   = blk_of(bpm_addr);

  // named internal events
  logic bpm_live, fetch_doomed, fetch_known, rec_go, fwd_hit;
  logic [ENTRIES-1:0]    slot_vld, slot_same, slot_cover, slot_doomed, slot_sel, slot_wr;
  logic [ENTRIES*BW-1:0] slot_blk_flat;
  logic [PW-1:0]         rr_ptr;

  assign bpm_live     = bpm_en & bpm_valid;
  assign fetch_doomed = (icm_valid & (icm_blk == fetch_blk)) |
                        (bpm_live  & (bpm_blk == fetch_blk));
  assign fetch_known  = |slot_same;
  assign rec_go       = fetch_valid & ~fetch_doomed & ~fetch_known;
  assign slot_wr      = slot_sel & {ENTRIES{rec_go}};

  sfw_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (rec_go),
    .ptr   (rr_ptr),
    .sel   (slot_sel)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    sfw_slot #(.BW(BW)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (slot_wr[i]),
      .wr_blk     (fetch_blk),
      .kill_a_en  (icm_valid),
      .kill_a_blk (icm_blk),
      .kill_b_en  (bpm_live),
      .kill_b_blk (bpm_blk),
      .probe_blk  (probe_blk),
      .look_blk   (fetch_blk),
      .vld        (slot_vld[i]),
      .blk        (slot_blk_flat[i*BW +: BW]),
      .same_look  (slot_same[i]),
      .covers     (slot_cover[i]),
      .doomed     (slot_doomed[i])
    );
  end

  // same-cycle forwarding of a committed fetch into the check
  sfw_near #(.BW(BW)) u_fwd (
    .en  (fetch_valid & ~fetch_doomed),
    .rec (fetch_blk),
    .tgt (probe_blk),
    .hit (fwd_hit)
  );

  assign probe_allow = probe_valid & ((|slot_cover) | fwd_hit);

endmodule

// File: rtl/spec_fetch_window_chk.sv
module spec_fetch_window_chk #(
  parameter int ADDR_W        = 32,
  parameter int GRANULE_BYTES = 4096,
  parameter int ENTRIES       = 8,
  localparam int GSH = sfw_pkg::gran_shift(GRANULE_BYTES),
  localparam int BW  = ADDR_W - GSH
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              probe_valid,
  input logic              probe_allow,
  input logic              icm_valid,
  input logic [ADDR_W-1:0] icm_addr,
  input logic              bpm_en,
  input logic              bpm_valid,
  input logic [ADDR_W-1:0] bpm_addr,
  input logic [ENTRIES-1:0]    slot_vld,
  input logic [ENTRIES*BW-1:0] slot_blk_flat,
  input logic              rec_go
);
  logic [BW-1:0] f_blk, i_blk, b_blk;
  assign f_blk = fetch_addr[ADDR_W-1:GSH];
  assign i_blk = icm_addr[ADDR_W-1:GSH];
  assign b_blk = bpm_addr[ADDR_W-1:GSH];

  function automatic logic holds(input logic [BW-1:0] b);
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      if (slot_vld[i] && slot_blk_flat[i*BW +: BW] == b) r = 1'b1;
    return r;
  endfunction

  function automatic logic has_dup();
    logic r;
    r = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      for (int j = i + 1; j < ENTRIES; j++)
        if (slot_vld[i] && slot_vld[j] &&
            slot_blk_flat[i*BW +: BW] == slot_blk_flat[j*BW +: BW]) r = 1'b1;
    return r;
  endfunction

  assert_reset_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slot_vld == '0));

  assert_fetch_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !(icm_valid && i_blk == f_blk) && !(bpm_en && bpm_valid && b_blk == f_blk))
    |=> holds($past(f_blk)));

  assert_icm_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    icm_valid |=> !holds($past(i_blk)));

  assert_bpm_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bpm_en && bpm_valid) |=> !holds($past(b_blk)));

  assert_maint_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && icm_valid && i_blk == f_blk) |-> !rec_go);

  assert_no_duplicate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !has_dup());

  assert_idle_deny_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_valid |-> !probe_allow);

  assert_empty_deny_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_vld == '0 && !fetch_valid) |-> !probe_allow);
endmodule

bind spec_fetch_window spec_fetch_window_chk #(
  .ADDR_W(ADDR_W), .GRANULE_BYTES(GRANULE_BYTES), .ENTRIES(ENTRIES)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_valid   (fetch_valid),
  .fetch_addr    (fetch_addr),
  .probe_valid   (probe_valid),
  .probe_allow   (probe_allow),
  .icm_valid     (icm_valid),
  .icm_addr      (icm_addr),
  .bpm_en        (bpm_en),
  .bpm_valid     (bpm_valid),
  .bpm_addr      (bpm_addr),
  .slot_vld      (slot_vld),
  .slot_blk_flat (slot_blk_flat),
  .rec_go        (rec_go)
);

// File: tb/spec_fetch_window_tb.sv
`timescale 1ns/1ps
module spec_fetch_window_tb;
  localparam int AW = 20;
  localparam int GB = 4096;
  localparam int N  = 4;
  localparam int NB = (1 << AW) / GB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 0, probe_valid = 0, icm_valid = 0, bpm_en = 0, bpm_valid = 0;
  logic [AW-1:0] fetch_addr = '0, probe_addr = '0, icm_addr = '0, bpm_addr = '0;
  logic probe_allow;

  int n_run = 0, n_fail = 0;
  int mslot [N];
  int mptr;

  always #2.5 clk = ~clk;

  spec_fetch_window #(.ADDR_W(AW), .GRANULE_BYTES(GB), .ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_allow(probe_allow),
    .icm_valid(icm_valid), .icm_addr(icm_addr),
    .bpm_en(bpm_en), .bpm_valid(bpm_valid), .bpm_addr(bpm_addr)
  );

  function automatic int bi(input logic [AW-1:0] a);
    return int'(a) / GB;
  endfunction

  function automatic bit killed(input int b);
    return (icm_valid && bi(icm_addr) == b) || (bpm_en && bpm_valid && bi(bpm_addr) == b);
  endfunction

  function automatic bit in_win(input int rec, input int tgt);
    return rec == tgt || ((rec + 1) % NB) == tgt;
  endfunction

  function automatic bit model_allow();
    bit r;
    r = 0;
    if (!probe_valid) return 0;
    foreach (mslot[i])
      if (mslot[i] >= 0 && !killed(mslot[i]) && in_win(mslot[i], bi(probe_addr))) r = 1;
    if (fetch_valid && !killed(bi(fetch_addr)) && in_win(bi(fetch_addr), bi(probe_addr))) r = 1;
    return r;
  endfunction

  task automatic model_clear();
    foreach (mslot[i]) mslot[i] = -1;
    mptr = 0;
  endtask

  task automatic model_step();
    bit present;
    int fb;
    fb = bi(fetch_addr);
    present = 0;
    foreach (mslot[i]) if (mslot[i] == fb) present = 1;
    foreach (mslot[i]) if (mslot[i] >= 0 && killed(mslot[i])) mslot[i] = -1;
    if (fetch_valid && !killed(fb) && !present) begin
      mslot[mptr] = fb;
      mptr = (mptr + 1) % N;
    end
  endtask

  task automatic check(input string tag, input bit got, input bit exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: probe_allow=%0b expected=%0b (probe 0x%05h)", tag, got, exp, probe_addr);
    end
  endtask

  // one cycle; hand < 0 means model comparison only
  task automatic cyc(input bit fv, input int fa, input bit pv, input int pa,
                     input bit iv, input int ia, input bit be, input bit bv, input int ba,
                     input string tag, input int hand);
    fetch_valid = fv; fetch_addr = AW'(fa);
    probe_valid = pv; probe_addr = AW'(pa);
    icm_valid = iv;   icm_addr = AW'(ia);
    bpm_en = be; bpm_valid = bv; bpm_addr = AW'(ba);
    #1;
    check({tag, " model"}, probe_allow, model_allow());
    if (hand >= 0) check({tag, " hand"}, probe_allow, hand[0]);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic probe(input int pa, input string tag, input int hand);
    cyc(0, 0, 1, pa, 0, 0, 0, 0, 0, tag, hand);
  endtask

  task automatic fetch(input int fa);
    cyc(1, fa, 0, 0, 0, 0, 0, 0, 0, "R10 idle", 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    fetch_valid = 0; probe_valid = 0; icm_valid = 0; bpm_valid = 0; bpm_en = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();
    // R3 reset state, R10 idle probe
    probe(32'h00000, "R3 after reset", 0);
    probe(32'h12345, "R3 after reset", 0);
    probe(32'hFFFFF, "R3 after reset", 0);
    cyc(0, 0, 0, 32'h00000, 0, 0, 0, 0, 0, "R10 no probe", 0);

    // R4 forwarding, R2 window, R1 granule boundaries
    cyc(1, 32'h03010, 1, 32'h03FF8, 0, 0, 0, 0, 0, "R4 same-cycle forward", 1);
    probe(32'h03000, "R2 same block", 1);
    probe(32'h04ABC, "R2 next block", 1);
    probe(32'h04FFF, "R1 last byte of next block", 1);
    probe(32'h05000, "R2 beyond window", 0);
    probe(32'h02FFF, "R1 byte below block", 0);
    cyc(1, 32'h03000, 1, 32'h03000, 0, 0, 0, 0, 0, "R9 repeat fetch", 1);

    // R5 icache maintenance clears, incl. same-cycle probe
    cyc(0, 0, 1, 32'h03000, 1, 32'h03800, 0, 0, 0, "R5 same-cycle clear", 0);
    probe(32'h04000, "R5 cleared next", 0);

    // R6 predictor maintenance gated by mode
    fetch(32'h07000);
    cyc(0, 0, 1, 32'h07000, 0, 0, 0, 1, 32'h07100, "R6 mode off", 1);
    probe(32'h08000, "R6 mode off kept", 1);
    cyc(0, 0, 0, 0, 0, 0, 1, 1, 32'h07100, "R10 idle", 0);
    probe(32'h08000, "R6 mode on cleared", 0);

    // R7 maintenance beats a record of the same block
    cyc(1, 32'h09000, 1, 32'h09000, 1, 32'h09FFF, 0, 0, 0, "R7 same cycle", 0);
    probe(32'h09000, "R7 not recorded", 0);
    cyc(1, 32'h0A000, 1, 32'h0B000, 0, 0, 1, 1, 32'h0A004, "R7 predictor wins", 0);
    probe(32'h0A000, "R7 predictor not recorded", 0);

    // R8 wrap at top
    do_reset();
    fetch(32'hFF800);
    probe(32'h00004, "R8 wrap to block 0", 1);
    probe(32'hFFFFF, "R8 top block", 1);
    probe(32'hFE000, "R8 below top", 0);

    // R9 round-robin replacement
    do_reset();
    fetch(32'h0A000); fetch(32'h14000); fetch(32'h1E000); fetch(32'h28000);
    probe(32'h0A000, "R9 full table", 1);
    fetch(32'h32000);
    probe(32'h0A000, "R9 oldest evicted", 0);
    probe(32'h14000, "R9 second kept", 1);
    fetch(32'h14000);
    fetch(32'h3C000);
    probe(32'h14000, "R9 repeat did not advance", 0);
    probe(32'h1E000, "R9 third kept", 1);
    probe(32'h3D000, "R9 newest next block", 1);

    // R3 reset mid-run
    do_reset();
    probe(32'h32000, "R3 reset clears", 0);
    probe(32'h3C000, "R3 reset clears", 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule